// File: doc/BRIEF.md
# CAN Controller Mode and Bit-Timing Register

This block is the 32-bit control word of a CAN controller. It holds the operating-mode bits and the bit-timing fields in one register. It also runs the request/acknowledge handshake that moves the protocol engine into and out of its configuration (init) state and its low-power (sleep) state. Software raises the init request, polls for the acknowledge, programs prescaler, segments, jump width and mode bits, then clears the request and polls until the acknowledge drops.

Each handshake is a small state machine with four states. `HS_RUN` is idle with the acknowledge low. `HS_ENTER_WAIT` counts out the engine latency while the request is high. `HS_ACTIVE` holds the acknowledge high. `HS_LEAVE_WAIT` counts out the same latency after the request is released. The transitions are:

- run→enter-wait when the request rises.
- enter-wait→active when the count reaches `ACK_DELAY`.
- enter-wait→run when the request is withdrawn early.
- active→leave-wait when the request falls.
- leave-wait→run when the count completes.
- leave-wait→active when the request is raised again.

The timing and mode fields accept writes only while the init acknowledge is high. The block also presents the timing fields to the bit-sampling engine in decoded form: actual quantum counts, clamped to the legal minimums.

Top module: `canctl_timing_reg`

## Requirements
- R1: After reset, `rd_data` reads 32'h0000_8000, both acknowledges are 0, and the decoded outputs are prescale 2, jump width 1, segment 1 = 4, segment 2 = 2, with the mode outputs at 0.
- R2: Bit 15 always reads 1. Bits 14, 11:10 and 7:2 always read 0. Writes to these bits have no effect.
- R3: Bit 0 (init request) is stored on every write. The init acknowledge (bit 8, `init_ack_o`) rises on the (ACK_DELAY+1)-th rising edge after the edge that stored a 1, and not earlier.
- R4: Clearing bit 0 while the acknowledge is high makes the acknowledge fall on the (ACK_DELAY+1)-th rising edge after that write, and not earlier.
- R5: A request withdrawn before its acknowledge arrives leaves the acknowledge at 0. A request raised again while the acknowledge is still falling keeps it at 1.
- R6: Bit 1 (sleep request) drives a separate handshake with the same latency. Its acknowledge reads in bit 9 and on `sleep_ack_o`, and it does not move the init acknowledge.
- R7: Bits 31:16, 13 and 12 take the written value only if the init acknowledge is 1 at the write edge. Otherwise they keep their value.
- R8: The decoded outputs are field+1: prescale from bits 21:16, jump width from bits 23:22, segment 1 from bits 27:24, segment 2 from bits 30:28. Prescale is raised to at least 2, segment 1 to at least 4 and segment 2 to at least 2. Read-back shows the raw stored fields.
- R9: `listen_only_o`, `loopback_o` and `triple_sample_o` follow stored bits 12, 13 and 31.
- R10: With `wr_en` low, no stored bit changes, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current control word with acknowledges |
| init_ack_o | output | 1 | Engine is in init state |
| sleep_ack_o | output | 1 | Engine is in sleep state |
| listen_only_o | output | 1 | Listen-only mode enable |
| loopback_o | output | 1 | Internal loopback enable |
| triple_sample_o | output | 1 | Three-sample mode enable |
| prescale_o | output | 7 | Decoded prescaler, 2..64 |
| sjw_o | output | 3 | Decoded resync jump width, 1..4 |
| tseg1_o | output | 5 | Decoded segment 1, 4..16 |
| tseg2_o | output | 4 | Decoded segment 2, 2..8 |

## Verification
The assertions assume that `ACK_DELAY` is at least 1 and that reset is held from time zero, so every register has a defined value before the first sampled edge. They also assume `wr_data` is fully known whenever `wr_en` is high. The bench drives writes only on falling edges. Apart from the directed handshake windows, it waits `ACK_DELAY`+3 cycles after each write before checking, so its model only needs the settled acknowledge. The abort and re-request windows are directed and timed against the write edge.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
    // bit positions that software and the engine decode
    localparam int unsigned INIT_REQ_BIT   = 0;
    localparam int unsigned SLEEP_REQ_BIT  = 1;
    localparam int unsigned INIT_ACK_BIT   = 8;
    localparam int unsigned SLEEP_ACK_BIT  = 9;
    localparam int unsigned LISTEN_BIT     = 12;
    localparam int unsigned LOOPBACK_BIT   = 13;
    localparam int unsigned ENABLED_BIT    = 15;
    localparam int unsigned TIMING_LSB     = 16;

    localparam int unsigned BRP_W   = 6;
    localparam int unsigned SJW_W   = 2;
    localparam int unsigned TSEG1_W = 4;
    localparam int unsigned TSEG2_W = 3;
    localparam int unsigned TIMING_W = 1 + TSEG2_W + TSEG1_W + SJW_W + BRP_W;

    localparam int unsigned HS_CHANNELS = 2;
    localparam int unsigned HS_INIT     = 0;
    localparam int unsigned HS_SLEEP    = 1;

    // upper half of the control word, MSB first
    typedef struct packed {
        logic               triple;
        logic [TSEG2_W-1:0] tseg2;
        logic [TSEG1_W-1:0] tseg1;
        logic [SJW_W-1:0]   sjw;
        logic [BRP_W-1:0]   brp;
    } timing_t;

    typedef enum logic [1:0] {
        HS_RUN,
        HS_ENTER_WAIT,
        HS_ACTIVE,
        HS_LEAVE_WAIT
    } hs_state_t;
endpackage

// File: rtl/canctl_handshake.sv
module canctl_handshake
    import canctl_pkg::*;
#(
    parameter int unsigned ACK_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o
);
    localparam int unsigned CW = $clog2(ACK_DELAY + 1) + 1;
    localparam logic [CW-1:0] CNT_DONE = CW'(ACK_DELAY);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    hs_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_RUN: begin
                if (req_i) begin
                    state_d = HS_ENTER_WAIT;
                    cnt_d   = CNT_ONE;
                end
            end
            HS_ENTER_WAIT: begin
                if (!req_i) begin
                    state_d = HS_RUN;
                end else if (cnt_q == CNT_DONE) begin
                    state_d = HS_ACTIVE;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            HS_ACTIVE: begin
                if (!req_i) begin
                    state_d = HS_LEAVE_WAIT;
                    cnt_d   = CNT_ONE;
                end
            end
            HS_LEAVE_WAIT: begin
                if (req_i) begin
                    state_d = HS_ACTIVE;
                end else if (cnt_q == CNT_DONE) begin
                    state_d = HS_RUN;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: begin
                state_d = HS_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs: the engine reports the mode until leaving is complete
    always_comb begin
        unique case (state_q)
            HS_ACTIVE, HS_LEAVE_WAIT: ack_o = 1'b1;
            default:                  ack_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/canctl_timing_decode.sv
module canctl_timing_decode
    import canctl_pkg::*;
#(
    parameter int unsigned BRP_MIN   = 2,
    parameter int unsigned TSEG1_MIN = 4,
    parameter int unsigned TSEG2_MIN = 2
) (
    input  timing_t              tim_i,
    output logic [BRP_W:0]       prescale_o,
    output logic [SJW_W:0]       sjw_o,
    output logic [TSEG1_W:0]     tseg1_o,
    output logic [TSEG2_W:0]     tseg2_o,
    output logic                 triple_o
);
    localparam logic [BRP_W:0]   BRP_LO   = (BRP_W+1)'(BRP_MIN);
    localparam logic [TSEG1_W:0] TSEG1_LO = (TSEG1_W+1)'(TSEG1_MIN);
    localparam logic [TSEG2_W:0] TSEG2_LO = (TSEG2_W+1)'(TSEG2_MIN);

    logic [BRP_W:0]   brp_raw;
    logic [TSEG1_W:0] tseg1_raw;
    logic [TSEG2_W:0] tseg2_raw;

    always_comb begin
        brp_raw   = {1'b0, tim_i.brp}   + (BRP_W+1)'(1);
        tseg1_raw = {1'b0, tim_i.tseg1} + (TSEG1_W+1)'(1);
        tseg2_raw = {1'b0, tim_i.tseg2} + (TSEG2_W+1)'(1);

        prescale_o = (brp_raw   < BRP_LO)   ? BRP_LO   : brp_raw;
        tseg1_o    = (tseg1_raw < TSEG1_LO) ? TSEG1_LO : tseg1_raw;
        tseg2_o    = (tseg2_raw < TSEG2_LO) ? TSEG2_LO : tseg2_raw;
        sjw_o      = {1'b0, tim_i.sjw} + (SJW_W+1)'(1);
        triple_o   = tim_i.triple;
    end
endmodule

// File: rtl/canctl_timing_reg.sv
module canctl_timing_reg
    import canctl_pkg::*;
#(
    parameter int unsigned ACK_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              init_ack_o,
    output logic              sleep_ack_o,
    output logic              listen_only_o,
    output logic              loopback_o,
    output logic              triple_sample_o,
    output logic [BRP_W:0]    prescale_o,
    output logic [SJW_W:0]    sjw_o,
    output logic [TSEG1_W:0]  tseg1_o,
    output logic [TSEG2_W:0]  tseg2_o
);
    logic [HS_CHANNELS-1:0] req_q;
    logic [HS_CHANNELS-1:0] ack_vec;
    logic                   listen_q;
    logic                   loop_q;
    timing_t                tim_q;
    logic                   cfg_open;
    logic                   unused_wr_bits;

    assign cfg_open       = ack_vec[HS_INIT];
    assign unused_wr_bits = ^{wr_data[15:14], wr_data[11:2]};

    // storage: requests always writable, configuration only in init
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            listen_q <= 1'b0;
            loop_q   <= 1'b0;
            tim_q    <= '0;
        end else if (wr_en) begin
            req_q[HS_INIT]  <= wr_data[INIT_REQ_BIT];
            req_q[HS_SLEEP] <= wr_data[SLEEP_REQ_BIT];
            if (cfg_open) begin
                tim_q    <= wr_data[TIMING_LSB +: TIMING_W];
                listen_q <= wr_data[LISTEN_BIT];
                loop_q   <= wr_data[LOOPBACK_BIT];
            end
        end
    end

    // one handshake machine per mode request
    for (genvar g = 0; g < HS_CHANNELS; g++) begin : g_hs
        canctl_handshake #(
            .ACK_DELAY (ACK_DELAY)
        ) i_hs (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_q[g]),
            .ack_o (ack_vec[g])
        );
    end

    canctl_timing_decode i_decode (
        .tim_i      (tim_q),
        .prescale_o (prescale_o),
        .sjw_o      (sjw_o),
        .tseg1_o    (tseg1_o),
        .tseg2_o    (tseg2_o),
        .triple_o   (triple_sample_o)
    );

    always_comb begin
        rd_data                              = '0;
        rd_data[INIT_REQ_BIT]                = req_q[HS_INIT];
        rd_data[SLEEP_REQ_BIT]               = req_q[HS_SLEEP];
        rd_data[INIT_ACK_BIT]                = ack_vec[HS_INIT];
        rd_data[SLEEP_ACK_BIT]               = ack_vec[HS_SLEEP];
        rd_data[LISTEN_BIT]                  = listen_q;
        rd_data[LOOPBACK_BIT]                = loop_q;
        rd_data[ENABLED_BIT]                 = 1'b1;
        rd_data[TIMING_LSB +: TIMING_W]      = tim_q;
    end

    assign init_ack_o    = ack_vec[HS_INIT];
    assign sleep_ack_o   = ack_vec[HS_SLEEP];
    assign listen_only_o = listen_q;
    assign loopback_o    = loop_q;
endmodule

// File: rtl/canctl_timing_reg_chk.sv
module canctl_timing_reg_chk #(
    parameter int unsigned ACK_DELAY = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data,
    input logic [6:0]  prescale_o,
    input logic [4:0]  tseg1_o,
    input logic [3:0]  tseg2_o
);
    localparam int unsigned CW = $clog2(ACK_DELAY + 2) + 1;
    localparam logic [CW-1:0] SAT = CW'(ACK_DELAY + 1);

    // cycles the init request has held its current level
    logic [CW-1:0] hi_run, lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else if (rd_data[0]) begin
            lo_run <= '0;
            if (hi_run != SAT) hi_run <= hi_run + CW'(1);
        end else begin
            hi_run <= '0;
            if (lo_run != SAT) lo_run <= lo_run + CW'(1);
        end
    end

    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] && (rd_data[14] == 1'b0) && (rd_data[11:10] == 2'b00) && (rd_data[7:2] == 6'd0));

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[8]) |-> $past(rd_data[0]));

    assert_ack_rise_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[8]) |-> (hi_run >= SAT));

    assert_ack_fall_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[8]) |-> (lo_run >= SAT));

    assert_sleep_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[9]) |-> $past(rd_data[1]));

    assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_data[8]) |-> $stable({rd_data[31:16], rd_data[13:12]}));

    assert_decode_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_o >= 7'd2) && (tseg1_o >= 5'd4) && (tseg2_o >= 4'd2));
endmodule

bind canctl_timing_reg canctl_timing_reg_chk #(.ACK_DELAY(ACK_DELAY)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .prescale_o (prescale_o),
    .tseg1_o    (tseg1_o),
    .tseg2_o    (tseg2_o)
);

// File: tb/test_canctl_timing_reg.sv
module test_canctl_timing_reg;
    localparam int unsigned D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        init_ack_o, sleep_ack_o, listen_only_o, loopback_o, triple_sample_o;
    logic [6:0]  prescale_o;
    logic [2:0]  sjw_o;
    logic [4:0]  tseg1_o;
    logic [3:0]  tseg2_o;

    always #5 clk = ~clk;

    canctl_timing_reg #(.ACK_DELAY(D)) i_canctl_timing_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .init_ack_o(init_ack_o), .sleep_ack_o(sleep_ack_o), .listen_only_o(listen_only_o),
        .loopback_o(loopback_o), .triple_sample_o(triple_sample_o), .prescale_o(prescale_o),
        .sjw_o(sjw_o), .tseg1_o(tseg1_o), .tseg2_o(tseg2_o)
    );

    int checks = 0;
    int fails  = 0;

    // model of the settled register
    bit          m_init, m_sleep, m_listen, m_loop;
    logic [15:0] m_tim;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        return {m_tim, 1'b1, 1'b0, m_loop, m_listen, 2'b00, m_sleep, m_init,
                6'd0, m_sleep, m_init};
    endfunction

    function automatic int floor_inc(int f, int mn);
        return (f + 1 < mn) ? mn : f + 1;
    endfunction

    function automatic logic [23:0] exp_dec();
        logic [6:0] p; logic [2:0] s; logic [4:0] t1; logic [3:0] t2;
        p  = 7'(floor_inc(int'(m_tim[5:0]), 2));
        s  = 3'(int'(m_tim[7:6]) + 1);
        t1 = 5'(floor_inc(int'(m_tim[11:8]), 4));
        t2 = 4'(floor_inc(int'(m_tim[14:12]), 2));
        return {p, s, t1, t2, m_listen, m_loop, m_tim[15], 2'b00};
    endfunction

    function automatic logic [31:0] cur_word(bit req);
        return {m_tim, 2'b00, m_loop, m_listen, 10'd0, m_sleep, req};
    endfunction

    task automatic raw_write(logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // only used when the handshake is settled
    task automatic model_write(logic [31:0] d);
        bit open;
        open = m_init;
        raw_write(d);
        if (open) begin
            m_tim    = d[31:16];
            m_listen = d[12];
            m_loop   = d[13];
        end
        m_init  = d[0];
        m_sleep = d[1];
    endtask

    task automatic settle();
        repeat (D + 3) @(negedge clk);
    endtask

    task automatic check_state(string tag);
        chk({tag, " word"}, 64'(rd_data), 64'(exp_rd()));
        chk({tag, " decode"},
            64'({prescale_o, sjw_o, tseg1_o, tseg2_o, listen_only_o, loopback_o,
                 triple_sample_o, 2'b00}), 64'(exp_dec()));
        chk({tag, " acks"}, 64'({init_ack_o, sleep_ack_o}), 64'({m_init, m_sleep}));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'h5eed_c0de));
        m_init = 0; m_sleep = 0; m_listen = 0; m_loop = 0; m_tim = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_state("R1 reset");
        chk("R1 reset value", 64'(rd_data), 64'h8000);

        // R7 configuration locked outside init; R2 fixed bits ignore writes
        model_write(32'hFFFF_7CFC);
        settle();
        check_state("R7 locked write");
        chk("R2 fixed bits", 64'(rd_data & 32'h0000_CCFC), 64'h8000);

        // R3 entry latency
        raw_write(32'h0000_0001);
        m_init = 1;
        repeat (D) @(negedge clk);
        chk("R3 ack early", 64'(rd_data[8]), 64'd0);
        @(negedge clk);
        chk("R3 ack on time", 64'(rd_data[8]), 64'd1);
        settle();

        // R8 R9 programming in init
        model_write({1'b1, 3'd3, 4'd7, 2'd2, 6'd9, 2'b00, 1'b1, 1'b1, 12'd1});
        settle();
        check_state("R8 R9 program");
        chk("R8 prescale", 64'(prescale_o), 64'd10);
        chk("R9 listen", 64'(listen_only_o), 64'd1);

        // R8 floors
        model_write({1'b0, 3'd0, 4'd1, 2'd3, 6'd0, 2'b00, 1'b0, 1'b0, 12'd1});
        settle();
        check_state("R8 floor");
        chk("R8 seg1 floor", 64'(tseg1_o), 64'd4);
        model_write({1'b0, 3'd7, 4'd15, 2'd0, 6'd63, 4'b0000, 12'd1});
        settle();
        check_state("R8 max");
        chk("R8 prescale max", 64'(prescale_o), 64'd64);

        // R10 no write without strobe
        @(negedge clk);
        wr_data = 32'hFFFF_FFFE;
        repeat (4) @(negedge clk);
        wr_data = '0;
        check_state("R10 idle bus");

        // R5 re-request during leave keeps ack high
        raw_write(cur_word(1'b0));
        repeat (3) @(negedge clk);
        raw_write(cur_word(1'b1));
        seen = 0;
        for (int i = 0; i < D + 3; i++) begin
            @(negedge clk);
            if (rd_data[8] !== 1'b1) seen = 1;
        end
        chk("R5 re-request", 64'(seen), 64'd0);

        // R4 leave latency
        raw_write(cur_word(1'b0));
        m_init = 0;
        repeat (D) @(negedge clk);
        chk("R4 ack early drop", 64'(rd_data[8]), 64'd1);
        @(negedge clk);
        chk("R4 ack drop on time", 64'(rd_data[8]), 64'd0);
        settle();
        check_state("R4 after leave");

        // R5 abort before acknowledge
        raw_write(32'h0000_0001);
        repeat (3) @(negedge clk);
        raw_write(32'h0000_0000);
        seen = 0;
        for (int i = 0; i < D + 3; i++) begin
            @(negedge clk);
            if (rd_data[8] !== 1'b0) seen = 1;
        end
        chk("R5 abort", 64'(seen), 64'd0);
        check_state("R5 after abort");

        // R6 sleep handshake
        raw_write(32'h0000_0002);
        m_sleep = 1;
        repeat (D) @(negedge clk);
        chk("R6 sleep ack early", 64'(rd_data[9]), 64'd0);
        @(negedge clk);
        chk("R6 sleep ack on time", 64'({rd_data[9], rd_data[8]}), 64'b10);
        settle();
        check_state("R6 sleep");
        model_write(32'h0);
        settle();

        // random mix, settled between writes
        for (int n = 0; n < 40; n++) begin
            logic [31:0] d;
            d = $urandom;
            model_write(d);
            settle();
            check_state("R7 R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule